// File: doc/BRIEF.md
# Chainable 8-Bit Timer Cell

This block is one 8-bit programmable function cell. A small register file, written through a simple write port, picks one of three functions (interval timer, gated event counter or pulse-width modulator) and routes the cell's inputs and outputs. One down-counting datapath serves all three functions, and the meaning of its compare register changes with the function.

Each block has three inputs:

- **Clock input.** A tick enable chosen from a 16-line source bus.
- **Data input.** Chosen from the same bus. It gates counting or triggers a capture.
- **Auxiliary input.** Chosen from a 4-line bus. It forces a reload of the period, either directly or through a two-stage synchronizer.

A terminal-count strobe leaves the cell on `chain_out`. Wiring it into the `chain_in` of a neighbour whose chain bit is set makes the two cells count as one 16-bit function.

Two outputs are steered onto one of four row lines:

- **Primary output.** Carries the function result.
- **Auxiliary output.** Carries the terminal-count strobe.

A registered interrupt pulse reports the event that belongs to the selected function.

Register map, by write/read address:

| Address | Contents |
|---|---|
| 0 | Count |
| 1 | Period |
| 2 | Compare/capture |
| 3 | Control: bit0 = run |
| 4 | Function: bits1:0 = mode (0 timer, 1 counter, 2 PWM, 3 behaves as timer); bit2 = chain enable |
| 5 | Input select: bits3:0 = clock source; bits7:4 = data source |
| 6 | Output config: bits1:0 = primary row; bit2 = primary enable; bit3 = auxiliary enable; bits5:4 = auxiliary row; bit6 = auxiliary synchronize |
| 7 | Auxiliary select: bits1:0 |

Unused bits read as zero.

Top module: `tmrc_top`

## Requirements
- R1: After reset every register reads zero, and `row_out` and `irq` are low.
- R2: A tick is a cycle in which all of the following hold: run is set, the selected clock source is high, chaining is off or `chain_in` is high, and (in counter mode) the data input is high. On each tick the count decrements; a tick at count 0 reloads the period. A period of P therefore repeats every P+1 ticks.
- R3: The clock source is `src_bus[insel[3:0]]` and the data source is `src_bus[insel[7:4]]`. A source line other than the selected one has no effect on counting.
- R4: In PWM mode the primary output is high while count <= compare. Over any P+1 consecutive ticks it is high for min(C,P)+1 of them.
- R5: `irq` pulses for one cycle, one clock after the event. The event is the terminal-count tick in counter and PWM modes, and a capture in timer mode.
- R6: In timer mode a rising edge on the data input while running copies the current count into the compare/capture register.
- R7: In counter mode the count holds while the data input is low.
- R8: `chain_out` is high during a tick at count 0. With function bit2 set, the cell ticks only while `chain_in` is high.
- R9: The primary output drives `row_out[outcfg[1:0]]` when outcfg bit2 is set. The terminal-count strobe drives `row_out[outcfg[5:4]]` when outcfg bit3 is set. A disabled output leaves every row low.
- R10: While running, a high auxiliary input (`aux_bus[auxsel]`) reloads the count from the period. The reload lands on the next edge when outcfg bit6 is clear, and on the third edge when it is set.
- R11: While run is clear the count holds and `row_out` and `irq` stay low. Writing run from 0 to 1 loads the count from the period.
- R12: A bus write to the count register takes priority over a tick or a reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| src_bus | input | 16 | Clock/data source lines |
| aux_bus | input | 4 | Auxiliary source lines |
| chain_in | input | 1 | Tick enable from the lower cell |
| chain_out | output | 1 | Terminal-count strobe to the upper cell |
| row_out | output | 4 | Row output lines |
| irq | output | 1 | Function interrupt pulse |

## Verification
A tick or a bus write applied before a rising edge shows in the count and capture registers just after that edge. `chain_out` and the steered `row_out` lines follow the registered count within the same cycle. `irq` trails its event by one edge. A synchronized auxiliary reload lands on the third edge after the line rises, and a direct one on the first. The bench drives inputs on falling edges and samples on falling edges exactly the number of edges later that each of these latencies gives. The PWM checks count highs and interrupts over windows of P+1 cycles, and those totals do not depend on phase.

// File: rtl/tmrc_pkg.sv
package tmrc_pkg;
    typedef enum logic [1:0] {
        FN_TIMER = 2'd0,
        FN_COUNT = 2'd1,
        FN_PWM   = 2'd2,
        FN_SPARE = 2'd3
    } fn_e;

    localparam int unsigned REG_AW = 3;
    localparam logic [REG_AW-1:0] A_COUNT  = 3'd0;
    localparam logic [REG_AW-1:0] A_PERIOD = 3'd1;
    localparam logic [REG_AW-1:0] A_CMP    = 3'd2;
    localparam logic [REG_AW-1:0] A_CTRL   = 3'd3;
    localparam logic [REG_AW-1:0] A_FUNC   = 3'd4;
    localparam logic [REG_AW-1:0] A_INSEL  = 3'd5;
    localparam logic [REG_AW-1:0] A_OUTCFG = 3'd6;
    localparam logic [REG_AW-1:0] A_AUXSEL = 3'd7;
endpackage

// File: rtl/tmrc_sel.sv
module tmrc_sel #(
    parameter int unsigned N  = 16,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  src,
    input  logic [IW-1:0] idx,
    output logic          y
);
    always_comb begin
        y = src[idx];
    end
endmodule

// File: rtl/tmrc_core.sv
module tmrc_core
    import tmrc_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          start,
    input  fn_e           fn,
    input  logic          chain_en,
    input  logic          chain_in,
    input  logic          clk_sel,
    input  logic          data_sel,
    input  logic          aux_reload,
    input  logic          wr_cnt,
    input  logic          wr_cmp,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] period,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] cmp,
    output logic          prim,
    output logic          tc,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] cmp;
        logic          data_prev;
        logic          irq;
    } core_s;

    core_s st_q, st_d;
    logic  tick, cap, is_timer;

    always_comb begin
        is_timer = (fn == FN_TIMER) || (fn == FN_SPARE);
        tick = run && clk_sel && (!chain_en || chain_in)
             && ((fn != FN_COUNT) || data_sel);
        tc   = tick && (st_q.cnt == '0);
        cap  = run && is_timer && data_sel && !st_q.data_prev;

        st_d = st_q;
        if (wr_cnt)
            st_d.cnt = wr_data;
        else if (start || aux_reload)
            st_d.cnt = period;
        else if (tick)
            st_d.cnt = (st_q.cnt == '0) ? period : st_q.cnt - 1'b1;

        if (wr_cmp)
            st_d.cmp = wr_data;
        else if (cap)
            st_d.cmp = st_q.cnt;

        st_d.data_prev = data_sel;
        st_d.irq       = run && (is_timer ? cap : tc);

        prim = run && ((fn == FN_PWM) ? (st_q.cnt <= st_q.cmp) : tc);
        cnt  = st_q.cnt;
        cmp  = st_q.cmp;
        irq  = st_q.irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a stopped cell with no write or reload keeps its count
    p_hold_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start && !wr_cnt && !aux_reload) |=> $stable(st_q.cnt));
    // R2: a tick away from zero steps the count down by one
    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt != '0 && !wr_cnt && !start && !aux_reload)
        |=> st_q.cnt == $past(st_q.cnt) - 1'b1);
    // R2: a tick at zero reloads the period
    p_wrap_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !wr_cnt && !start && !aux_reload) |=> st_q.cnt == $past(period));
    // R5: the interrupt only follows a run-time event one cycle earlier
    p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(run) && ($past(tc) || $past(cap)));
    // R12: a count write always lands
    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> st_q.cnt == $past(wr_data));
endmodule

// File: rtl/tmrc_steer.sv
module tmrc_steer #(
    parameter int unsigned NROW = 4,
    localparam int unsigned RW  = $clog2(NROW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prim,
    input  logic            auxo,
    input  logic            prim_en,
    input  logic            aux_en,
    input  logic [RW-1:0]   prim_row,
    input  logic [RW-1:0]   aux_row,
    output logic [NROW-1:0] row_out
);
    for (genvar r = 0; r < NROW; r++) begin : g_row
        assign row_out[r] = (prim_en && prim && (prim_row == RW'(r)))
                         || (aux_en && auxo && (aux_row == RW'(r)));
    end

    // R9: no enabled source means every row line is low
    p_rows_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!prim_en && !aux_en) |-> row_out == '0);
    // R9: a single enabled source reaches at most one row
    p_single_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_en |-> $onehot0(row_out));
endmodule

// File: rtl/tmrc_top.sv
module tmrc_top
    import tmrc_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned NSRC = 16,
    parameter int unsigned NAUX = 4,
    parameter int unsigned NROW = 4,
    localparam int unsigned SW  = $clog2(NSRC),
    localparam int unsigned AW  = $clog2(NAUX),
    localparam int unsigned RW  = $clog2(NROW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [NSRC-1:0]   src_bus,
    input  logic [NAUX-1:0]   aux_bus,
    input  logic              chain_in,
    output logic              chain_out,
    output logic [NROW-1:0]   row_out,
    output logic              irq
);
    typedef struct packed {
        logic [DW-1:0] period;
        logic          run;
        fn_e           fn;
        logic          chain;
        logic [SW-1:0] clk_idx;
        logic [SW-1:0] dat_idx;
        logic [RW-1:0] prow;
        logic          pen;
        logic          aen;
        logic [RW-1:0] arow;
        logic          sync;
        logic [AW-1:0] aux_idx;
        logic          s1;
        logic          s2;
    } cfg_s;

    cfg_s cf_q, cf_d;
    logic start, wr_cnt, wr_cmp, aux_raw, aux_reload;
    logic clk_sel, data_sel, prim, tc;
    logic [DW-1:0] cnt, cmp;

    always_comb begin
        cf_d   = cf_q;
        start  = wr_en && (wr_addr == A_CTRL) && wr_data[0] && !cf_q.run;
        wr_cnt = wr_en && (wr_addr == A_COUNT);
        wr_cmp = wr_en && (wr_addr == A_CMP);
        if (wr_en) begin
            unique case (wr_addr)
                A_PERIOD: cf_d.period = wr_data;
                A_CTRL:   cf_d.run    = wr_data[0];
                A_FUNC: begin
                    cf_d.fn    = fn_e'(wr_data[1:0]);
                    cf_d.chain = wr_data[2];
                end
                A_INSEL: begin
                    cf_d.clk_idx = wr_data[SW-1:0];
                    cf_d.dat_idx = wr_data[2*SW-1:SW];
                end
                A_OUTCFG: begin
                    cf_d.prow = wr_data[RW-1:0];
                    cf_d.pen  = wr_data[2];
                    cf_d.aen  = wr_data[3];
                    cf_d.arow = wr_data[4+RW-1:4];
                    cf_d.sync = wr_data[6];
                end
                A_AUXSEL: cf_d.aux_idx = wr_data[AW-1:0];
                default: ;
            endcase
        end
        cf_d.s1    = aux_raw;
        cf_d.s2    = cf_q.s1;
        aux_reload = cf_q.run && (cf_q.sync ? cf_q.s2 : aux_raw);

        rd_data = '0;
        unique case (rd_addr)
            A_COUNT:  rd_data = cnt;
            A_PERIOD: rd_data = cf_q.period;
            A_CMP:    rd_data = cmp;
            A_CTRL:   rd_data[0] = cf_q.run;
            A_FUNC:   rd_data[2:0] = {cf_q.chain, cf_q.fn};
            A_INSEL:  rd_data[2*SW-1:0] = {cf_q.dat_idx, cf_q.clk_idx};
            A_OUTCFG: begin
                rd_data[RW-1:0]   = cf_q.prow;
                rd_data[2]        = cf_q.pen;
                rd_data[3]        = cf_q.aen;
                rd_data[4+RW-1:4] = cf_q.arow;
                rd_data[6]        = cf_q.sync;
            end
            A_AUXSEL: rd_data[AW-1:0] = cf_q.aux_idx;
            default: ;
        endcase
        chain_out = tc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cf_q <= '0;
        else        cf_q <= cf_d;
    end

    tmrc_sel #(.N(NSRC)) u_clk_sel (.src(src_bus), .idx(cf_q.clk_idx), .y(clk_sel));
    tmrc_sel #(.N(NSRC)) u_dat_sel (.src(src_bus), .idx(cf_q.dat_idx), .y(data_sel));
    tmrc_sel #(.N(NAUX)) u_aux_sel (.src(aux_bus), .idx(cf_q.aux_idx), .y(aux_raw));

    tmrc_core #(.DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .run(cf_q.run), .start(start), .fn(cf_q.fn),
        .chain_en(cf_q.chain), .chain_in(chain_in), .clk_sel(clk_sel),
        .data_sel(data_sel), .aux_reload(aux_reload), .wr_cnt(wr_cnt),
        .wr_cmp(wr_cmp), .wr_data(wr_data), .period(cf_q.period),
        .cnt(cnt), .cmp(cmp), .prim(prim), .tc(tc), .irq(irq)
    );

    tmrc_steer #(.NROW(NROW)) u_steer (
        .clk(clk), .rst_n(rst_n), .prim(prim), .auxo(tc),
        .prim_en(cf_q.pen), .aux_en(cf_q.aen), .prim_row(cf_q.prow),
        .aux_row(cf_q.arow), .row_out(row_out)
    );

    // R11: a cell stopped for two cycles drives no rows and no interrupt
    p_quiet_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cf_q.run && !$past(cf_q.run)) |-> (row_out == '0) && !irq);
    // R8: with chaining on, no chain_in means no terminal-count strobe
    p_chain_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_q.chain && !chain_in) |-> !chain_out);
endmodule

// File: tb/tb_tmrc_top.sv
module tb_tmrc_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_en_h = 1'b0;
    logic [2:0] wr_addr = '0, wr_addr_h = '0, rd_addr = '0, rd_addr_h = '0;
    logic [7:0] wr_data = '0, wr_data_h = '0, rd_data, rd_data_h;
    logic [15:0] src_bus = '0, src_h = '1;
    logic [3:0] aux_bus = '0, row_out, row_h;
    logic chain_lo, chain_hi, irq, irq_h;
    int n_vec = 0, n_bad = 0, cyc = 0;
    logic [7:0] v, v2;

    always #4 clk = ~clk;

    tmrc_top dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .src_bus(src_bus),
        .aux_bus(aux_bus), .chain_in(1'b0), .chain_out(chain_lo),
        .row_out(row_out), .irq(irq));

    tmrc_top dut_hi (.clk(clk), .rst_n(rst_n), .wr_en(wr_en_h), .wr_addr(wr_addr_h),
        .wr_data(wr_data_h), .rd_addr(rd_addr_h), .rd_data(rd_data_h), .src_bus(src_h),
        .aux_bus(4'b0), .chain_in(chain_lo), .chain_out(chain_hi),
        .row_out(row_h), .irq(irq_h));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_h(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_h = 1'b1; wr_addr_h = a; wr_data_h = d;
        @(negedge clk);
        wr_en_h = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic setup(input logic [7:0] fn, per, cmpv, insel, outc, auxs);
        wr(3'd3, 8'h00);
        wr(3'd1, per);
        wr(3'd2, cmpv);
        wr(3'd4, fn);
        wr(3'd5, insel);
        wr(3'd6, outc);
        wr(3'd7, auxs);
        wr(3'd3, 8'h01);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(1'b0, "watchdog", cyc, 0);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk(v == 8'h00, "R1 register reset", v, 0);
        end
        chk(row_out == 4'h0 && !irq, "R1 outputs low", row_out, 0);

        // R4, R5, R9: PWM duty and interrupt rate over a period window
        src_bus = '1;
        for (int pi = 0; pi < 2; pi++) begin
            for (int c = 0; c <= 7; c++) begin
                int p, hi, ir, other, row;
                p = (pi == 0) ? 3 : 6;
                if (c > p + 1) continue;
                row = c % 4;
                setup(8'h02, 8'(p), 8'(c), 8'h00, 8'(4 | row), 8'h00);
                repeat (3) @(negedge clk);
                hi = 0; ir = 0; other = 0;
                for (int k = 0; k <= p; k++) begin
                    @(negedge clk);
                    hi += int'(row_out[row]);
                    ir += int'(irq);
                    other += int'((row_out & ~(4'b1 << row)) != 0);
                end
                chk(hi == ((c < p ? c : p) + 1), "R4 pwm high count", hi, (c < p ? c : p) + 1);
                chk(ir == 1, "R5 one irq per period", ir, 1);
                chk(other == 0, "R9 other rows low", other, 0);
            end
        end

        // R11: stop holds count and quiets outputs; start reloads
        wr(3'd3, 8'h00);
        @(negedge clk);
        rd(3'd0, v);
        repeat (5) @(negedge clk);
        rd(3'd0, v2);
        chk(v == v2, "R11 count holds when stopped", v2, v);
        chk(row_out == 4'h0 && !irq, "R11 outputs low when stopped", row_out, 0);
        src_bus = '0;
        wr(3'd0, 8'h07);
        wr(3'd3, 8'h01);
        rd(3'd0, v);
        chk(v == 8'd6, "R11 start reloads period", v, 6);

        // R12: bus write to count wins over a tick
        src_bus = '1;
        wr(3'd0, 8'h22);
        rd(3'd0, v);
        chk(v == 8'h21 || v == 8'h22, "R12 write lands", v, 8'h22);
        @(negedge wr_en ? clk : clk);
        src_bus = '0;

        // R3, R2: clock source sweep
        for (int s = 0; s < 16; s++) begin
            src_bus = '0;
            setup(8'h00, 8'd200, 8'h00, 8'({4'((s + 1) % 16), 4'(s)}), 8'h00, 8'h00);
            src_bus = 16'h1 << s;
            repeat (10) @(negedge clk);
            src_bus = ~(16'h1 << s);
            repeat (5) @(negedge clk);
            rd(3'd0, v);
            chk(v == 8'd190, "R3 only selected clock counts", v, 190);
        end

        // R7: counter mode gated by data input
        src_bus = 16'h0001;
        setup(8'h01, 8'd50, 8'h00, 8'h10, 8'h00, 8'h00);
        repeat (6) @(negedge clk);
        rd(3'd0, v);
        chk(v == 8'd50, "R7 holds with data low", v, 50);
        src_bus = 16'h0003;
        repeat (4) @(negedge clk);
        src_bus = 16'h0001;
        rd(3'd0, v);
        chk(v == 8'd46, "R7 counts with data high", v, 46);

        // R6, R5: timer capture on data rising edge
        src_bus = '0;
        setup(8'h00, 8'h40, 8'h00, 8'h20, 8'h00, 8'h00);
        wr(3'd0, 8'h5A);
        chk(!irq, "R5 no irq before capture", irq, 0);
        src_bus = 16'h0004;
        @(negedge clk);
        chk(irq, "R5 capture irq one cycle later", irq, 1);
        @(negedge clk);
        chk(!irq, "R5 irq is a single pulse", irq, 0);
        rd(3'd2, v);
        chk(v == 8'h5A, "R6 capture value", v, 8'h5A);
        src_bus = '0;

        // R10: direct and synchronized auxiliary reload
        setup(8'h00, 8'h30, 8'h00, 8'h00, 8'h00, 8'h01);
        wr(3'd0, 8'h10);
        aux_bus = 4'b0010;
        @(negedge clk);
        aux_bus = '0;
        rd(3'd0, v);
        chk(v == 8'h30, "R10 direct reload next edge", v, 8'h30);
        wr(3'd6, 8'h40);
        repeat (3) @(negedge clk);
        wr(3'd0, 8'h10);
        aux_bus = 4'b0010;
        @(negedge clk);
        rd(3'd0, v);
        chk(v == 8'h10, "R10 sync edge 1", v, 8'h10);
        @(negedge clk);
        rd(3'd0, v);
        chk(v == 8'h10, "R10 sync edge 2", v, 8'h10);
        @(negedge clk);
        rd(3'd0, v);
        chk(v == 8'h30, "R10 sync reload edge 3", v, 8'h30);
        aux_bus = '0;

        // R8, R9: two cells chained, aux strobe on row 2
        src_bus = '0;
        setup(8'h00, 8'd3, 8'h00, 8'h00, 8'h28, 8'h00);
        wr_h(3'd1, 8'd2);
        wr_h(3'd4, 8'h04);
        wr_h(3'd3, 8'h01);
        repeat (3) @(negedge clk);
        rd_addr_h = 3'd0;
        #1 chk(rd_data_h == 8'd2, "R8 upper holds without chain", rd_data_h, 2);
        src_bus = 16'h0001;
        repeat (3) @(negedge clk);
        chk(chain_lo, "R8 chain_out at zero tick", chain_lo, 1);
        chk(row_out == 4'b0100, "R9 aux strobe on row 2", row_out, 4);
        repeat (5) @(negedge clk);
        src_bus = '0;
        rd(3'd0, v);
        chk(v == 8'd3, "R8 lower after 8 ticks", v, 3);
        #1 chk(rd_data_h == 8'd0, "R8 upper stepped twice", rd_data_h, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule